// File: doc/BRIEF.md
# Frame-sync serial DAC write controller

This block sends one 16-bit command word to a serial DAC for each sample code it accepts. A 10-bit code enters through a valid/ready handshake and is registered when it is accepted. The block places the code between a fixed 4-bit command prefix and two zero padding bits. It then runs a complete write frame on four lines: an active-low chip select, a frame-sync strobe, a serial clock and serial data.

The DAC restarts its input shift register on a rising frame-sync edge and samples data on falling clock edges. The block therefore drops chip select and gives frame sync a low-high-low pulse before any clock edge. It then clocks out 16 bits, most significant first, with the clock idling low and data changing on the rising edge. At the end it raises frame sync and then chip select. Each minimum setup and pulse time is a parameter in picoseconds. It is converted to system-clock cycles with upward rounding, so no window falls short of its minimum.

Top module: `fsdac_writer`

## Requirements
- R1: The word sent is 0x4000 OR (code << 2): bits 15..12 are 0100, bits 11..2 carry the code and bits 1..0 are 0. Bit 15 is sent first.
- R2: The serial clock is low outside the shift phase. Data changes only while the clock rises, never when it falls. Each frame has exactly 16 falling clock edges.
- R3: In each frame, frame sync goes low, then high, then low again before the first clock edge, and goes high again after the 16th falling edge. There is no clock edge while frame sync is high.
- R4: The frame-sync high pulse before clocking lasts at least FS_HI_PS.
- R5: Chip select is low at least CS_FS_PS before the frame-sync fall that precedes clocking.
- R6: Frame sync is low at least FS_CK_PS before the first falling clock edge.
- R7: The 16th falling clock edge comes at least C16_FS_PS before frame sync rises.
- R8: Chip select rises only after frame sync is already high.
- R9: ready_o is high only when idle and busy_o is high for the whole frame. A valid_i asserted during a frame does not start another frame.
- R10: The code is captured on the accepting edge. Changes on code_i later in the frame do not alter the word being sent.
- R11: While reset is asserted and right after it, cs_no and fs_o are high, sclk_o and sdo_o are low, ready_o is high and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 10 | Sample code |
| valid_i | input | 1 | Code is valid |
| ready_o | output | 1 | Block is idle and can accept a code |
| busy_o | output | 1 | A frame is in progress |
| cs_no | output | 1 | DAC chip select, active low |
| fs_o | output | 1 | DAC frame sync |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data |

## Verification
The hardest cases to reach are requests that arrive while a frame is in progress. Two kinds matter: a new valid pulse and a changing code bus. In both, the only visible effect is that nothing changes. The bench makes each frame scramble code_i on the cycle after acceptance. In a directed test it also pulses valid_i in the middle of a frame, and then checks both the captured word and that no second frame follows. A monitor timestamps every chip-select, frame-sync and clock edge. Each timing window is then checked in nanoseconds against its minimum, independently of the cycle counts the design derives.

// File: rtl/fsdac_pkg.sv
package fsdac_pkg;
  localparam int CODE_W = 10;
  localparam int WORD_W = 16;
  localparam logic [3:0] CMD_PREFIX = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_FSH, ST_FSL, ST_SHIFT, ST_POST, ST_END
  } fs_state_e;

  function automatic logic [WORD_W-1:0] build_word(input logic [CODE_W-1:0] code);
    return {CMD_PREFIX, code, 2'b00};
  endfunction

  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    int c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/fsdac_gap_timer.sv
module fsdac_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fsdac_shreg.sv
module fsdac_shreg
  import fsdac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              shift_i,
  output logic              sdo_o
);
  logic [WORD_W-1:0] word_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sdo_q  <= 1'b0;
    end else if (load_i) begin
      word_q <= build_word(code_i);
      sdo_q  <= 1'b0;
    end else if (shift_i) begin
      sdo_q  <= word_q[WORD_W-1];
      word_q <= {word_q[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/fsdac_seq.sv
module fsdac_seq
  import fsdac_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int N_PRE  = 2,
  parameter int N_FSH  = 4,
  parameter int N_FSL  = 2,
  parameter int N_POST = 2,
  parameter int N_HALF = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             sh_load_o,
  output logic             sh_shift_o,
  output logic             ready_o,
  output logic             busy_o,
  output logic             cs_no,
  output logic             fs_o,
  output logic             sclk_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  fs_state_e        st_q, st_d;
  logic             sclk_q, sclk_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      bit_q  <= '0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
    end
  end

  always_comb begin
    st_d       = st_q;
    sclk_d     = sclk_q;
    bit_d      = bit_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sh_load_o  = 1'b0;
    sh_shift_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (valid_i) begin
        st_d = ST_PRE; sh_load_o = 1'b1;
        tmr_load_o = 1'b1; tmr_val_o = CNT_W'(N_PRE - 1);
      end
      ST_PRE: if (tmr_zero_i) begin
        st_d = ST_FSH;
        tmr_load_o = 1'b1; tmr_val_o = CNT_W'(N_FSH - 1);
      end
      ST_FSH: if (tmr_zero_i) begin
        st_d = ST_FSL;
        tmr_load_o = 1'b1; tmr_val_o = CNT_W'(N_FSL - 1);
      end
      ST_FSL: if (tmr_zero_i) begin
        st_d = ST_SHIFT; sclk_d = 1'b1; sh_shift_o = 1'b1; bit_d = '0;
        tmr_load_o = 1'b1; tmr_val_o = CNT_W'(N_HALF - 1);
      end
      ST_SHIFT: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        if (sclk_q) begin
          sclk_d = 1'b0;  // falling edge: receiver samples here
          if (bit_q == LAST_BIT) begin
            st_d = ST_POST; tmr_val_o = CNT_W'(N_POST - 1);
          end else begin
            tmr_val_o = CNT_W'(N_HALF - 1);
          end
        end else begin
          sclk_d = 1'b1; sh_shift_o = 1'b1; bit_d = bit_q + 1'b1;
          tmr_val_o = CNT_W'(N_HALF - 1);
        end
      end
      ST_POST: if (tmr_zero_i) st_d = ST_END;
      ST_END:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ready_o = (st_q == ST_IDLE);
  assign busy_o  = (st_q != ST_IDLE);
  assign cs_no   = (st_q == ST_IDLE);
  assign fs_o    = (st_q == ST_IDLE) || (st_q == ST_FSH) || (st_q == ST_END);
  assign sclk_o  = sclk_q;
endmodule

// File: rtl/fsdac_writer.sv
module fsdac_writer
  import fsdac_pkg::*;
#(
  parameter int CLK_PS    = 5000,
  parameter int FS_HI_PS  = 20000,
  parameter int CS_FS_PS  = 10000,
  parameter int FS_CK_PS  = 8000,
  parameter int C16_FS_PS = 10000,
  parameter int HALF_CYC  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [9:0]  code_i,
  input  logic        valid_i,
  output logic        ready_o,
  output logic        busy_o,
  output logic        cs_no,
  output logic        fs_o,
  output logic        sclk_o,
  output logic        sdo_o
);
  localparam int N_FSH  = ps_to_cyc(FS_HI_PS, CLK_PS);
  localparam int N_CSF  = ps_to_cyc(CS_FS_PS, CLK_PS);
  // chip select falls with the first frame-sync fall; the high pulse counts toward its lead
  localparam int N_PRE  = (N_CSF > N_FSH) ? (N_CSF - N_FSH) : 1;
  localparam int N_FSL  = ps_to_cyc(FS_CK_PS, CLK_PS);
  localparam int N_POST = ps_to_cyc(C16_FS_PS, CLK_PS);
  localparam int N_HALF = (HALF_CYC < 1) ? 1 : HALF_CYC;
  localparam int M1     = (N_FSH > N_PRE) ? N_FSH : N_PRE;
  localparam int M2     = (N_FSL > N_POST) ? N_FSL : N_POST;
  localparam int M3     = (M1 > M2) ? M1 : M2;
  localparam int N_MAX  = (M3 > N_HALF) ? M3 : N_HALF;
  localparam int CNT_W  = $clog2(N_MAX + 1);

  logic             tmr_load, tmr_zero, sh_load, sh_shift;
  logic [CNT_W-1:0] tmr_val;

  fsdac_gap_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  fsdac_shreg u_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sh_load), .code_i(code_i),
    .shift_i(sh_shift), .sdo_o(sdo_o)
  );

  fsdac_seq #(
    .CNT_W(CNT_W), .N_PRE(N_PRE), .N_FSH(N_FSH), .N_FSL(N_FSL),
    .N_POST(N_POST), .N_HALF(N_HALF)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .sh_load_o(sh_load),
    .sh_shift_o(sh_shift), .ready_o(ready_o), .busy_o(busy_o),
    .cs_no(cs_no), .fs_o(fs_o), .sclk_o(sclk_o)
  );
endmodule

// File: rtl/fsdac_writer_chk.sv
module fsdac_writer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic busy_o,
  input logic cs_no,
  input logic fs_o,
  input logic sclk_o,
  input logic sdo_o
);
  AST_SCLK_LOW_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);  // R2
  AST_SDO_STABLE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdo_o));  // R2
  AST_NO_CLK_FS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_o |-> !sclk_o);  // R3
  AST_CS_AFTER_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $past(fs_o));  // R8
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cs_no && fs_o && !sclk_o));  // R9
  AST_BUSY_HOLDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> !$past(cs_no) || !cs_no || fs_o);  // R9
endmodule

bind fsdac_writer fsdac_writer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .busy_o(busy_o),
  .cs_no(cs_no), .fs_o(fs_o), .sclk_o(sclk_o), .sdo_o(sdo_o)
);

// File: tb/fsdac_writer_tb.sv
module fsdac_writer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] code_i = '0;
  logic       valid_i = 1'b0;
  logic       ready_o, busy_o, cs_no, fs_o, sclk_o, sdo_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  fsdac_writer u_dut (.*);

  // code, expected word
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {10'h000, 16'h4000}, {10'h3FF, 16'h4FFC}, {10'h155, 16'h4554},
    {10'h2AA, 16'h4AA8}, {10'h001, 16'h4004}, {10'h200, 16'h4800}};

  // edge monitor, sampled on falling clock edge
  int cyc = 0, frames = 0;
  int t_cs, t_fsr, t_fsf, t_ck1, t_ck16, pw, lead, post, nbits;
  logic [15:0] cap;
  logic p_cs = 1, p_fs = 1, p_sclk = 0, cs_after_fs = 0, clk_while_fs = 0;
  logic fs_seq_ok = 0;

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni) begin
      if (p_cs && !cs_no) begin
        t_cs = cyc; nbits = 0; cap = '0; clk_while_fs = 0; fs_seq_ok = 0;
      end
      if (!cs_no && !p_fs && fs_o) begin
        if (nbits == 0) t_fsr = cyc; else begin post = cyc - t_ck16; end
      end
      if (!cs_no && p_fs && !fs_o) begin
        t_fsf = cyc; pw = cyc - t_fsr; lead = cyc - t_cs;
        fs_seq_ok = (t_fsr > t_cs);
      end
      if (p_sclk != sclk_o && fs_o) clk_while_fs = 1;
      if (p_sclk && !sclk_o) begin
        if (nbits == 0) t_ck1 = cyc;
        t_ck16 = cyc; cap = {cap[14:0], sdo_o}; nbits++;
      end
      if (!p_cs && cs_no) begin
        cs_after_fs = p_fs; frames++;
      end
    end
    p_cs = cs_no; p_fs = fs_o; p_sclk = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_frame(input int start);
    for (int i = 0; i < 400 && frames == start; i++) @(negedge clk_i);
    #1;
  endtask

  task automatic send(input logic [9:0] code, input logic [15:0] exp);
    int f0;
    while (!ready_o) @(negedge clk_i);
    f0 = frames;
    code_i = code; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; code_i = ~code;  // R10 scramble after acceptance
    chk(busy_o && !ready_o, "R9", "busy after accept", {busy_o, ready_o}, 2'b10);
    wait_frame(f0);
    chk(cap == exp, "R1", "word", cap, exp);
    chk(nbits == 16, "R2", "falling edges", nbits, 16);
    chk(fs_seq_ok && !clk_while_fs, "R3", "fs low-high-low order", {fs_seq_ok, clk_while_fs}, 2'b10);
    chk(pw * 5 >= 20, "R4", "fs pulse ns", pw * 5, 20);
    chk(lead * 5 >= 10, "R5", "cs lead ns", lead * 5, 10);
    chk((t_ck1 - t_fsf) * 5 >= 8, "R6", "fs to clk ns", (t_ck1 - t_fsf) * 5, 8);
    chk(post * 5 >= 10, "R7", "clk16 to fs ns", post * 5, 10);
    chk(cs_after_fs, "R8", "cs after fs", cs_after_fs, 1);
  endtask

  initial begin
    int f1;
    repeat (3) @(negedge clk_i);
    chk(cs_no && fs_o && !sclk_o && !sdo_o && ready_o && !busy_o, "R11", "in reset",
        {cs_no, fs_o, sclk_o, sdo_o, ready_o, busy_o}, 6'b110010);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no && fs_o && !sclk_o && !sdo_o && ready_o && !busy_o, "R11", "after reset",
        {cs_no, fs_o, sclk_o, sdo_o, ready_o, busy_o}, 6'b110010);

    for (int i = 0; i < NV; i++) send(VEC[i][25:16], VEC[i][15:0]);

    // R9: valid pulse mid-frame must not start another frame
    f1 = frames;
    code_i = 10'h0F0; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (20) @(negedge clk_i);
    code_i = 10'h30F; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    wait_frame(f1);
    chk(cap == 16'h43C0, "R10", "word with mid-frame request", cap, 16'h43C0);
    repeat (60) @(negedge clk_i);
    chk(frames == f1 + 1 && cs_no, "R9", "no extra frame", frames - f1, 1);

    // R11: reset mid-frame returns lines to idle
    code_i = 10'h3C3; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (15) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(cs_no && fs_o && !sclk_o && !sdo_o && ready_o, "R11", "mid-frame reset",
        {cs_no, fs_o, sclk_o, sdo_o, ready_o}, 5'b11001);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    send(10'h123, 16'h448C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule